// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates a set of level-sensitive request lines for a single processor. Every source carries a programmable priority, and a few low-numbered sources can also be raised and dropped by software. A current-priority register holds the level of the handler that is running. The registered processor request goes high only while some pending source is ranked strictly above that level.

Software takes an interrupt by reading the acknowledge address. That read returns the winning source number, saves the old current priority on a hardware stack, and raises the current priority to the winner's level. Writing the end-of-interrupt address pops the stack and restores the saved level. The stack is as deep as the number of priority levels, so it cannot fill as long as every preemption raises the level. Sticky flags report a push onto a full stack and a pop from an empty one.

Nesting is only bounded when priorities strictly increase. Software that writes the current priority below the running handler's own level can nest more deeply than the stack holds. A source whose flag a handler clears must also sit at or below that handler's level. Otherwise it can raise the request before the clear lands.

Top module: `prio_intc`

## Requirements
- R1: After a synchronous reset the following are all 0: `irq_out`, both stack flags, `reg_rdata`, the current priority, every source priority and every software flag.
- R2: Priority register n sits at address 0x40+n and holds the priorities of sources 4n..4n+3. Source 4n+j uses bits [8j+PW-1:8j]. Other bits are ignored on write and read back as 0.
- R3: `irq_out` is registered. It is 1 in the cycle after a cycle in which some pending source has a nonzero priority strictly above the current priority, and 0 otherwise. A priority of 0 never raises it.
- R4: A read of address 0x01 when a source qualifies returns bit 31 set with the winner's number in the low bits. The winner is the qualifying source with the highest priority, and the lowest source number wins a tie. The read saves the current priority on the stack and loads the winner's priority. If no source qualifies, the read returns 0 and changes nothing.
- R5: Any write to address 0x02 pops the stack into the current priority. If the stack is empty, the current priority becomes 0 and the sticky underflow flag (status bit 1, `lifo_unf`) is set.
- R6: The stack holds 2**PW entries. An acknowledge that finds it full still loads the winner's priority, but the saved value is dropped and the sticky overflow flag (status bit 0, `lifo_ovf`) is set.
- R7: Address 0x00 reads and writes the current priority in its low PW bits. Upper bits of a write are ignored.
- R8: Address 0x04 controls the software flags. On a write, bits [NUM_SW-1:0] set flags, bits [16+NUM_SW-1:16] clear them, and a clear wins over a set of the same flag. A read returns the flags in bits [NUM_SW-1:0]. Flag k is ORed with request line k.
- R9: Address 0x03 reads the two sticky flags as {underflow, overflow} in bits 1:0. Writing 1 to a bit clears that flag.
- R10: While a handler runs at priority P, a pending source at or below P leaves `irq_out` low. A pending source above P raises it, even if the running handler is about to clear it.
- R11: Reads of unmapped addresses return 0, and every read result appears on `reg_rdata` one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_SRC | Level-sensitive request lines |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered request to the processor |
| lifo_ovf | output | 1 | Sticky stack overflow flag |
| lifo_unf | output | 1 | Sticky stack underflow flag |

## Verification
The bench builds the controller with 16 sources, 4 of them software-settable, and 3-bit priorities, which gives an 8-deep stack. The shallow stack makes an overflow reachable in nine acknowledges once software lowers the current priority. With 16 sources, random traffic regularly produces ties and nested preemptions. Four priority registers also let every field position be written and read back within a short run.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 8;
  localparam logic [7:0] ADR_CUR  = 8'h00;
  localparam logic [7:0] ADR_ACK  = 8'h01;
  localparam logic [7:0] ADR_EOI  = 8'h02;
  localparam logic [7:0] ADR_STAT = 8'h03;
  localparam logic [7:0] ADR_SW   = 8'h04;
  localparam logic [7:0] ADR_PSEL = 8'h40;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 256,
  parameter int NUM_SW  = 8,
  parameter int PW      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [31:0]             wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [31:0]             rd_word,
  output logic [NUM_SRC*PW-1:0]   prio_flat,
  output logic [NUM_SW-1:0]       sw_flags
);
  localparam int NUM_PREG = (NUM_SRC + 3) / 4;

  logic [PW-1:0] prio_q [NUM_SRC];

  // priority fields, four sources per word
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NUM_PREG; r++) begin
        for (int j = 0; j < 4; j++) begin
          if (wr_addr == ADDR_W'(ADR_PSEL + r) && (4 * r + j) < NUM_SRC)
            prio_q[4 * r + j] <= wdata[8 * j +: PW];
        end
      end
    end
  end

  // software flags: clear beats set
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_flags <= '0;
    end else if (wr_en && wr_addr == ADR_SW) begin
      for (int k = 0; k < NUM_SW; k++) begin
        if (wdata[16 + k])   sw_flags[k] <= 1'b0;
        else if (wdata[k])   sw_flags[k] <= 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_flat
      assign prio_flat[g * PW +: PW] = prio_q[g];
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (rd_addr == ADR_SW) rd_word[NUM_SW-1:0] = sw_flags;
    for (int r = 0; r < NUM_PREG; r++) begin
      for (int j = 0; j < 4; j++) begin
        if (rd_addr == ADDR_W'(ADR_PSEL + r) && (4 * r + j) < NUM_SRC)
          rd_word[8 * j +: PW] = prio_q[4 * r + j];
      end
    end
  end

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_SW && wdata[16 +: NUM_SW] != '0)
      |=> ((sw_flags & $past(wdata[16 +: NUM_SW])) == '0));

  a_r2_field_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_PSEL)
      |=> (prio_flat[PW-1:0] == $past(wdata[PW-1:0])));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 256,
  parameter int PW      = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    pend,
  input  logic [NUM_SRC*PW-1:0] prio_flat,
  input  logic [PW-1:0]         cur_pri,
  output logic                  win_valid,
  output logic [IDX_W-1:0]      win_idx,
  output logic [PW-1:0]         win_prio
);
  // scan downward so that on equal priority the lower number overwrites
  always_comb begin
    win_prio = '0;
    win_idx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i] && prio_flat[i * PW +: PW] != '0 &&
          prio_flat[i * PW +: PW] >= win_prio) begin
        win_prio = prio_flat[i * PW +: PW];
        win_idx  = IDX_W'(i);
      end
    end
  end

  assign win_valid = win_prio > cur_pri;

  a_r4_winner_pending: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (pend[win_idx] && prio_flat[win_idx * PW +: PW] == win_prio));
endmodule

// File: rtl/intc_lifo.sv
module intc_lifo #(
  parameter int PW    = 4,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] dout,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_m1;

  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign cnt_m1 = cnt - CNT_W'(1);

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[PTR_W-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (push && !full)  cnt <= cnt + CNT_W'(1);
    else if (pop && !empty)  cnt <= cnt_m1;
  end

  assign dout = empty ? '0 : mem[cnt_m1[PTR_W-1:0]];

  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  a_r5_pop_returns_push: assert property (@(posedge clk) disable iff (rst)
    (push && !full) ##1 (pop && !push) |-> (dout == $past(din)));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 256,
  parameter int NUM_SW  = 8,
  parameter int PW      = 4,
  localparam int DEPTH  = 2 ** PW,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_out,
  output logic               lifo_ovf,
  output logic               lifo_unf
);
  logic [NUM_SRC*PW-1:0] prio_flat;
  logic [NUM_SW-1:0]     sw_flags;
  logic [31:0]           cfg_word;
  logic [NUM_SRC-1:0]    pend;
  logic                  win_valid;
  logic [IDX_W-1:0]      win_idx;
  logic [PW-1:0]         win_prio;
  logic [PW-1:0]         cur_pri;
  logic [PW-1:0]         stk_top;
  logic                  stk_full, stk_empty;
  logic                  ack, push, eoi, wr_cur, wr_stat;

  intc_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW), .PW(PW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr), .wdata(reg_wdata),
    .rd_addr(reg_addr), .rd_word(cfg_word), .prio_flat(prio_flat), .sw_flags(sw_flags)
  );

  assign pend = irq_lines | {{(NUM_SRC - NUM_SW){1'b0}}, sw_flags};

  intc_arbiter #(.NUM_SRC(NUM_SRC), .PW(PW)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .prio_flat(prio_flat), .cur_pri(cur_pri),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  assign ack     = reg_rd && reg_addr == ADR_ACK;
  assign push    = ack && win_valid;
  assign eoi     = reg_wr && reg_addr == ADR_EOI;
  assign wr_cur  = reg_wr && reg_addr == ADR_CUR;
  assign wr_stat = reg_wr && reg_addr == ADR_STAT;

  intc_lifo #(.PW(PW), .DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst(rst), .push(push), .pop(eoi), .din(cur_pri),
    .dout(stk_top), .full(stk_full), .empty(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst)          cur_pri <= '0;
    else if (push)    cur_pri <= win_prio;
    else if (eoi)     cur_pri <= stk_top;
    else if (wr_cur)  cur_pri <= reg_wdata[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lifo_ovf <= 1'b0;
      lifo_unf <= 1'b0;
    end else begin
      if (push && stk_full)          lifo_ovf <= 1'b1;
      else if (wr_stat && reg_wdata[0]) lifo_ovf <= 1'b0;
      if (eoi && stk_empty)          lifo_unf <= 1'b1;
      else if (wr_stat && reg_wdata[1]) lifo_unf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= win_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADR_CUR:  reg_rdata <= {{(32 - PW){1'b0}}, cur_pri};
        ADR_ACK:  reg_rdata <= win_valid ? {1'b1, {(31 - IDX_W){1'b0}}, win_idx} : '0;
        ADR_STAT: reg_rdata <= {30'd0, lifo_unf, lifo_ovf};
        default:  reg_rdata <= cfg_word;
      endcase
    end
  end

  a_r4_ack_raises: assert property (@(posedge clk) disable iff (rst)
    push |=> (cur_pri > $past(cur_pri)));

  a_r5_underflow: assert property (@(posedge clk) disable iff (rst)
    (eoi && stk_empty && !push) |=> (lifo_unf && cur_pri == '0));

  a_r6_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && stk_full) |=> lifo_ovf);

  a_r3_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|pend));
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam int NS = 16;
  localparam int NW = 4;
  localparam int PW = 3;
  localparam int DEPTH = 8;
  localparam int PMASK = DEPTH - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] lines = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_out, lifo_ovf, lifo_unf;

  int nchk = 0, nfail = 0;

  prio_intc #(.NUM_SRC(NS), .NUM_SW(NW), .PW(PW)) i_prio_intc (
    .clk(clk), .rst(rst), .irq_lines(lines), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .lifo_ovf(lifo_ovf), .lifo_unf(lifo_unf)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural model ----------------
  int  mprio[NS];
  bit  msw[NW];
  int  mcur;
  int  mstk[$];
  bit  movf, munf, mirq, mrd_chk;
  logic [31:0] mrd;

  function automatic logic [31:0] mread(input logic [7:0] a, input bit v, input int bi);
    logic [31:0] w = '0;
    if (a == 8'h00) w = mcur;
    else if (a == 8'h01) w = v ? (32'h8000_0000 | bi) : 32'h0;
    else if (a == 8'h03) w = {30'd0, munf, movf};
    else if (a == 8'h04) begin
      for (int k = 0; k < NW; k++) w[k] = msw[k];
    end else if (a >= 8'h40 && a < 8'h40 + NS / 4) begin
      for (int j = 0; j < 4; j++) w[8 * j +: 8] = 8'(mprio[(a - 8'h40) * 4 + j]);
    end
    return w;
  endfunction

  always @(posedge clk) begin
    int bp, bi;
    bit v, p;
    if (rst) begin
      for (int i = 0; i < NS; i++) mprio[i] = 0;
      for (int k = 0; k < NW; k++) msw[k] = 0;
      mcur = 0; mstk.delete(); movf = 0; munf = 0; mirq = 0; mrd = 0; mrd_chk = 0;
    end else begin
      bp = 0; bi = 0;
      for (int i = NS - 1; i >= 0; i--) begin
        p = lines[i] || (i < NW && msw[i]);
        if (p && mprio[i] != 0 && mprio[i] >= bp) begin bp = mprio[i]; bi = i; end
      end
      v = bp > mcur;
      mrd_chk = reg_rd;
      if (reg_rd) begin
        mrd = mread(reg_addr, v, bi);
        if (reg_addr == 8'h01 && v) begin
          if (mstk.size() == DEPTH) movf = 1; else mstk.push_back(mcur);
          mcur = bp;
        end
      end
      if (reg_wr) begin
        if (reg_addr == 8'h00) mcur = reg_wdata & PMASK;
        else if (reg_addr == 8'h02) begin
          if (mstk.size() == 0) begin mcur = 0; munf = 1; end
          else mcur = mstk.pop_back();
        end else if (reg_addr == 8'h03) begin
          if (reg_wdata[0]) movf = 0;
          if (reg_wdata[1]) munf = 0;
        end else if (reg_addr == 8'h04) begin
          for (int k = 0; k < NW; k++)
            if (reg_wdata[16 + k]) msw[k] = 0; else if (reg_wdata[k]) msw[k] = 1;
        end else if (reg_addr >= 8'h40 && reg_addr < 8'h40 + NS / 4) begin
          for (int j = 0; j < 4; j++)
            mprio[(reg_addr - 8'h40) * 4 + j] = (reg_wdata >> (8 * j)) & PMASK;
        end
      end
      mirq = v;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(irq_out == mirq, "R3 irq model", 32'(irq_out), 32'(mirq));
      chk(lifo_ovf == movf, "R6 ovf model", 32'(lifo_ovf), 32'(movf));
      chk(lifo_unf == munf, "R5 unf model", 32'(lifo_unf), 32'(munf));
      if (mrd_chk) chk(reg_rdata == mrd, "R11 rdata model", reg_rdata, mrd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq_out == 0 && lifo_ovf == 0 && lifo_unf == 0, "R1 outputs", {irq_out, lifo_ovf, lifo_unf}, 0);
    chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
    rd(8'h00, 0, "R1 cur");
    rd(8'h40, 0, "R1 prio");
    rd(8'h04, 0, "R1 sw");
    // R2 field layout and masking
    wr(8'h40, 32'h0705_0301);
    rd(8'h40, 32'h0705_0301, "R2 readback");
    wr(8'h41, 32'hFFFF_FFFF);
    rd(8'h41, 32'h0707_0707, "R2 mask");
    wr(8'h41, 32'h0000_0606);
    rd(8'h41, 32'h0000_0606, "R2 reg1");
    rd(8'h20, 0, "R11 unmapped");
    // R3 registered request
    lines[2] = 1'b1;
    @(negedge clk);
    chk(irq_out == 1, "R3 rise", irq_out, 1);
    lines[2] = 1'b0;
    @(negedge clk);
    chk(irq_out == 0, "R3 fall", irq_out, 0);
    lines[15] = 1'b1;
    idle(2);
    chk(irq_out == 0, "R3 prio zero", irq_out, 0);
    lines[15] = 1'b0;
    // R4 highest priority wins
    lines[1] = 1'b1; lines[2] = 1'b1;
    rd(8'h01, 32'h8000_0002, "R4 ack");
    rd(8'h00, 5, "R4 cur loaded");
    idle(1);
    chk(irq_out == 0, "R10 lower pending masked", irq_out, 0);
    // tie: sources 4 and 5 at 6
    lines[4] = 1'b1; lines[5] = 1'b1;
    rd(8'h01, 32'h8000_0004, "R4 tie lowest");
    rd(8'h01, 0, "R4 none qualifies");
    rd(8'h00, 6, "R4 unchanged");
    lines = '0;
    // R5 pops
    wr(8'h02, 0);
    rd(8'h00, 5, "R5 pop");
    wr(8'h02, 0);
    rd(8'h00, 0, "R5 pop2");
    wr(8'h02, 0);
    chk(lifo_unf == 1, "R5 underflow", lifo_unf, 1);
    rd(8'h03, 2, "R9 status unf");
    wr(8'h03, 2);
    rd(8'h03, 0, "R9 clear");
    // R10 ordering of cleared sources
    lines[2] = 1'b1;
    rd(8'h01, 32'h8000_0002, "R10 enter isr");
    lines[2] = 1'b0;
    wr(8'h04, 32'h1);
    idle(1);
    chk(irq_out == 0, "R10 at-or-below stays low", irq_out, 0);
    wr(8'h04, 32'h8);
    idle(1);
    chk(irq_out == 1, "R10 above raises", irq_out, 1);
    rd(8'h04, 32'h9, "R8 flags read");
    wr(8'h04, 32'h0009_0009);
    rd(8'h04, 0, "R8 clear wins");
    idle(1);
    chk(irq_out == 0, "R8 cleared drops", irq_out, 0);
    wr(8'h02, 0);
    // R7 current priority register
    wr(8'h00, 32'h1F);
    rd(8'h00, 7, "R7 masked");
    wr(8'h00, 0);
    // R6 overflow by lowering within handlers
    lines[1] = 1'b1;
    for (int n = 0; n < DEPTH + 1; n++) begin
      wr(8'h00, 0);
      rd(8'h01, 32'h8000_0001, "R6 ack");
    end
    chk(lifo_ovf == 1, "R6 overflow", lifo_ovf, 1);
    rd(8'h00, 3, "R6 prio loaded");
    rd(8'h03, 1, "R9 status ovf");
    wr(8'h03, 1);
    lines = '0;
    // random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      int op = $urandom_range(0, 9);
      lines = NS'($urandom) & NS'($urandom);
      case (op)
        0, 1: begin reg_rd = 1'b1; reg_addr = 8'h01; end
        2, 3: begin reg_wr = 1'b1; reg_addr = 8'h02; end
        4: begin reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = $urandom; end
        5: begin reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = $urandom; end
        6: begin reg_wr = 1'b1; reg_addr = 8'h40 + 8'($urandom_range(0, 3)); reg_wdata = $urandom; end
        7: begin reg_wr = 1'b1; reg_addr = 8'h03; reg_wdata = $urandom; end
        default: begin reg_rd = 1'b1; reg_addr = 8'($urandom_range(0, 8'h45)); end
      endcase
      @(negedge clk);
      reg_rd = 1'b0; reg_wr = 1'b0;
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule